// File: doc/BRIEF.md
# Double-Error-Correcting Memory Word Codec

This block protects 32-bit words held in an external memory with a 45-bit code. The encoder is combinational. It takes a data word and produces a systematic codeword: the data sits unchanged in the low 32 bits, twelve check bits follow, and one overall parity bit sits on top. The check bits come from a shortened binary BCH code with a minimum distance of five. The overall parity bit raises the distance to six.

The decoder takes a 45-bit word read back from memory. It computes a 12-bit syndrome and the overall parity, and compares the syndrome in parallel against the precomputed signature of every single-bit and every two-bit error position. It does not run any iterative error-locator search. Its result is registered, so the decision is available one clock after the word is sampled. The decoder reports:

- the repaired data;
- a flag saying a repair was made;
- how many bits were repaired;
- a flag for words it cannot repair.

Top module: `bch45_codec`

## Requirements
- R1: The encoder places the data word unchanged in codeword bits [31:0].
- R2: Codeword bits [43:32] hold the remainder of d(x)·x^12 divided by g(x) = x^12+x^10+x^8+x^5+x^4+x^3+1. Data bit i is the coefficient of x^(12+i), and codeword bit 32+k is the coefficient of x^k.
- R3: Codeword bit 44 is chosen so that the 45-bit codeword has an even number of ones.
- R4: A valid codeword presented on dec_cw_i yields that word's data on dec_data_o one clock later, with dec_corrected_o=0, dec_uncorr_o=0 and dec_nerr_o=0.
- R5: A codeword with any one of its 45 bits inverted yields the original data one clock later, with dec_corrected_o=1, dec_nerr_o=1 and dec_uncorr_o=0.
- R6: A codeword with any two of its 45 bits inverted yields the original data one clock later, with dec_corrected_o=1, dec_nerr_o=2 and dec_uncorr_o=0.
- R7: A codeword with any three bits inverted is flagged one clock later. The outputs are dec_uncorr_o=1, dec_corrected_o=0 and dec_nerr_o=0, and dec_data_o carries the received bits [31:0] unchanged.
- R8: While rst is high at a rising clock edge, all decoder outputs are cleared to zero.
- R9: dec_corrected_o and dec_uncorr_o are never high together. dec_nerr_o is nonzero exactly when dec_corrected_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the decoder result register |
| rst | input | 1 | Synchronous active-high reset |
| enc_data_i | input | 32 | Data word to encode |
| enc_cw_o | output | 45 | Codeword for enc_data_i (combinational) |
| dec_cw_i | input | 45 | Word read from memory to be decoded |
| dec_data_o | output | 32 | Repaired data, or raw data if the word cannot be repaired |
| dec_corrected_o | output | 1 | One or two bits were repaired |
| dec_nerr_o | output | 2 | Number of bits repaired (0, 1 or 2) |
| dec_uncorr_o | output | 1 | Error pattern could not be repaired |

## Verification
The bench goes after every one of the 45 single-bit and 990 two-bit error positions on several data words. This includes errors that hit the overall parity bit alone, or the parity bit together with one other bit. A decoder that mishandled those cases would either leave the word unrepaired or flip a data bit that was sound. Random three-bit patterns check that an odd error count whose syndrome matches no single column is rejected rather than miscorrected into a wrong data word. The check bits are compared against a polynomial long division done in the bench, so a wrong generator or a bit-order mix-up shows up directly on the encoder output.

// File: rtl/bch45_pkg.sv
package bch45_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 12;
    localparam int BASE_W = DATA_W + CHK_W;
    localparam int CW_W   = BASE_W + 1;
    localparam int NERR_W = 2;
    // generator low coefficients (x^12 implied): x^10+x^8+x^5+x^4+x^3+1
    localparam logic [CHK_W-1:0] GEN_LOW = 12'h539;

    typedef logic [CHK_W-1:0]  syn_t;
    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic [CW_W-1:0]   flip;
        logic              corrected;
        logic [NERR_W-1:0] nerr;
        logic              uncorr;
    } loc_t;

    typedef struct packed {
        data_t             data;
        logic              corrected;
        logic [NERR_W-1:0] nerr;
        logic              uncorr;
    } dec_res_t;

    // exponent carried by codeword bit b in the polynomial view
    function automatic int bit_power(input int b);
        return (b < DATA_W) ? b + CHK_W : b - DATA_W;
    endfunction

    // x^bit_power(b) mod g(x): the syndrome signature of codeword bit b
    function automatic syn_t column(input int b);
        syn_t r;
        logic msb;
        r = syn_t'(1);
        for (int k = 0; k < bit_power(b); k++) begin
            msb = r[CHK_W-1];
            r   = r << 1;
            if (msb) r = r ^ GEN_LOW;
        end
        return r;
    endfunction

endpackage

// File: rtl/bch45_encoder.sv
module bch45_encoder
    import bch45_pkg::*;
(
    input  data_t data_i,
    output cw_t   cw_o
);
    syn_t terms [DATA_W];
    syn_t rem;

    for (genvar i = 0; i < DATA_W; i++) begin : g_term
        localparam syn_t COL = column(i);
        assign terms[i] = data_i[i] ? COL : '0;
    end

    always_comb begin
        rem = '0;
        for (int i = 0; i < DATA_W; i++) rem = rem ^ terms[i];
    end

    assign cw_o = {^{rem, data_i}, rem, data_i};
endmodule

// File: rtl/bch45_syndrome.sv
module bch45_syndrome
    import bch45_pkg::*;
(
    input  cw_t  cw_i,
    output syn_t syn_o,
    output logic par_o
);
    syn_t terms [BASE_W];

    for (genvar b = 0; b < BASE_W; b++) begin : g_term
        localparam syn_t COL = column(b);
        assign terms[b] = cw_i[b] ? COL : '0;
    end

    always_comb begin
        syn_o = '0;
        for (int b = 0; b < BASE_W; b++) syn_o = syn_o ^ terms[b];
    end

    assign par_o = ^cw_i;
endmodule

// File: rtl/bch45_locator.sv
module bch45_locator
    import bch45_pkg::*;
(
    input  syn_t syn_i,
    input  logic par_i,
    output loc_t loc_o
);
    logic [BASE_W-1:0] single_hit;
    logic [BASE_W-1:0] pair_flip;
    // symmetric pair-match matrix: mm[i][j] is high when the syndrome equals col(i)^col(j)
    wire  [BASE_W-1:0] mm [BASE_W];

    for (genvar i = 0; i < BASE_W; i++) begin : g_row
        localparam syn_t COL_I = column(i);
        assign single_hit[i] = (syn_i == COL_I);
        for (genvar j = 0; j < BASE_W; j++) begin : g_col
            localparam syn_t COL_J = column(j);
            if (j == i) begin : g_diag
                assign mm[i][j] = 1'b0;
            end else if (j > i) begin : g_upper
                assign mm[i][j] = (syn_i == (COL_I ^ COL_J));
            end else begin : g_lower
                assign mm[i][j] = mm[j][i];
            end
        end
        assign pair_flip[i] = |mm[i];
    end

    always_comb begin
        loc_o = '0;
        if (par_i) begin
            // odd error count: one error, or give up
            if (syn_i == '0) begin
                loc_o.flip[CW_W-1] = 1'b1;
                loc_o.corrected    = 1'b1;
                loc_o.nerr         = 2'd1;
            end else if (|single_hit) begin
                loc_o.flip[BASE_W-1:0] = single_hit;
                loc_o.corrected        = 1'b1;
                loc_o.nerr             = 2'd1;
            end else begin
                loc_o.uncorr = 1'b1;
            end
        end else if (syn_i != '0) begin
            // even error count: two errors, one of which may be the parity bit
            if (|single_hit) begin
                loc_o.flip[BASE_W-1:0] = single_hit;
                loc_o.flip[CW_W-1]     = 1'b1;
                loc_o.corrected        = 1'b1;
                loc_o.nerr             = 2'd2;
            end else if (|pair_flip) begin
                loc_o.flip[BASE_W-1:0] = pair_flip;
                loc_o.corrected        = 1'b1;
                loc_o.nerr             = 2'd2;
            end else begin
                loc_o.uncorr = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bch45_codec.sv
module bch45_codec
    import bch45_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] enc_data_i,
    output logic [44:0] enc_cw_o,
    input  logic [44:0] dec_cw_i,
    output logic [31:0] dec_data_o,
    output logic        dec_corrected_o,
    output logic [1:0]  dec_nerr_o,
    output logic        dec_uncorr_o
);
    syn_t     syn;
    logic     par;
    loc_t     loc;
    cw_t      fixed;
    dec_res_t res_d, res_q;

    bch45_encoder u_enc (
        .data_i (enc_data_i),
        .cw_o   (enc_cw_o)
    );

    bch45_syndrome u_syn (
        .cw_i  (dec_cw_i),
        .syn_o (syn),
        .par_o (par)
    );

    bch45_locator u_loc (
        .syn_i (syn),
        .par_i (par),
        .loc_o (loc)
    );

    assign fixed = dec_cw_i ^ loc.flip;

    always_comb begin
        res_d.data      = loc.uncorr ? dec_cw_i[DATA_W-1:0] : fixed[DATA_W-1:0];
        res_d.corrected = loc.corrected;
        res_d.nerr      = loc.nerr;
        res_d.uncorr    = loc.uncorr;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign dec_data_o      = res_q.data;
    assign dec_corrected_o = res_q.corrected;
    assign dec_nerr_o      = res_q.nerr;
    assign dec_uncorr_o    = res_q.uncorr;
endmodule

// File: rtl/bch45_codec_chk.sv
module bch45_codec_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] enc_data_i,
    input logic [44:0] enc_cw_o,
    input logic [44:0] dec_cw_i,
    input logic [31:0] dec_data_o,
    input logic        dec_corrected_o,
    input logic [1:0]  dec_nerr_o,
    input logic        dec_uncorr_o
);
    p_sys_data_r1: assert property (@(posedge clk) disable iff (rst)
        enc_cw_o[31:0] == enc_data_i);

    p_even_par_r3: assert property (@(posedge clk) disable iff (rst)
        ($countones(enc_cw_o) % 2) == 0);

    p_clean_r4: assert property (@(posedge clk) disable iff (rst)
        (dec_cw_i == enc_cw_o) |=> (!dec_corrected_o && !dec_uncorr_o &&
            dec_nerr_o == 2'd0 && dec_data_o == $past(enc_data_i)));

    p_single_r5: assert property (@(posedge clk) disable iff (rst)
        ($countones(dec_cw_i ^ enc_cw_o) == 1) |=> (dec_corrected_o &&
            dec_nerr_o == 2'd1 && dec_data_o == $past(enc_data_i)));

    p_double_r6: assert property (@(posedge clk) disable iff (rst)
        ($countones(dec_cw_i ^ enc_cw_o) == 2) |=> (dec_corrected_o &&
            dec_nerr_o == 2'd2 && dec_data_o == $past(enc_data_i)));

    p_triple_r7: assert property (@(posedge clk) disable iff (rst)
        ($countones(dec_cw_i ^ enc_cw_o) == 3) |=> (dec_uncorr_o &&
            !dec_corrected_o && dec_data_o == $past(dec_cw_i[31:0])));

    p_reset_r8: assert property (@(posedge clk)
        rst |=> (dec_data_o == '0 && !dec_corrected_o && !dec_uncorr_o &&
            dec_nerr_o == 2'd0));

    p_flag_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(dec_corrected_o && dec_uncorr_o));

    p_nerr_link_r9: assert property (@(posedge clk) disable iff (rst)
        (dec_nerr_o != 2'd0) == dec_corrected_o);
endmodule

bind bch45_codec bch45_codec_chk u_chk (.*);

// File: tb/bch45_codec_tb.sv
`timescale 1ns/1ps
module bch45_codec_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] enc_data_i = 32'hDEADBEEF;
    logic [44:0] enc_cw_o;
    logic [44:0] dec_cw_i = {45{1'b1}};
    logic [31:0] dec_data_o;
    logic        dec_corrected_o;
    logic [1:0]  dec_nerr_o;
    logic        dec_uncorr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        corr;
        logic [1:0]  nerr;
        logic        unc;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    bch45_codec u_dut (
        .clk             (clk),
        .rst             (rst),
        .enc_data_i      (enc_data_i),
        .enc_cw_o        (enc_cw_o),
        .dec_cw_i        (dec_cw_i),
        .dec_data_o      (dec_data_o),
        .dec_corrected_o (dec_corrected_o),
        .dec_nerr_o      (dec_nerr_o),
        .dec_uncorr_o    (dec_uncorr_o)
    );

    // polynomial long division by g(x) = x^12+x^10+x^8+x^5+x^4+x^3+1
    function automatic logic [11:0] ref_rem(input logic [31:0] d);
        logic [43:0] v;
        v = {d, 12'b0};
        for (int k = 43; k >= 12; k--)
            if (v[k]) v[k-:13] = v[k-:13] ^ 13'h1539;
        return v[11:0];
    endfunction

    function automatic logic [44:0] ref_cw(input logic [31:0] d);
        logic [11:0] r;
        r = ref_rem(d);
        return {^{r, d}, r, d};
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic compare_head();
        exp_t e;
        if (q.size() == 0) return;
        e = q.pop_front();
        checks++;
        if (dec_data_o !== e.data || dec_corrected_o !== e.corr ||
            dec_nerr_o !== e.nerr || dec_uncorr_o !== e.unc) begin
            fails++;
            $display("FAIL %s: got data=%h corr=%b nerr=%0d unc=%b exp data=%h corr=%b nerr=%0d unc=%b",
                     e.tag, dec_data_o, dec_corrected_o, dec_nerr_o, dec_uncorr_o,
                     e.data, e.corr, e.nerr, e.unc);
        end
    endtask

    // each negedge: check the result of the word driven one clock earlier, then drive the next
    task automatic send(input logic [44:0] cw, input logic [31:0] d,
                        input logic [31:0] xd, input logic xc, input logic [1:0] xn,
                        input logic xu, input string tag);
        exp_t e;
        @(negedge clk);
        compare_head();
        enc_data_i = d;
        dec_cw_i   = cw;
        e.data = xd; e.corr = xc; e.nerr = xn; e.unc = xu; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic check_encoder(input logic [31:0] d);
        logic [44:0] exp_cw;
        @(negedge clk);
        compare_head();
        enc_data_i = d;
        #1;
        exp_cw = ref_cw(d);
        checks++;
        if (enc_cw_o[31:0] !== d) begin
            fails++;
            $display("FAIL R1: data field got %h exp %h", enc_cw_o[31:0], d);
        end
        checks++;
        if (enc_cw_o[43:32] !== exp_cw[43:32]) begin
            fails++;
            $display("FAIL R2: check bits got %h exp %h", enc_cw_o[43:32], exp_cw[43:32]);
        end
        checks++;
        if (enc_cw_o[44] !== exp_cw[44]) begin
            fails++;
            $display("FAIL R3: parity bit got %b exp %b", enc_cw_o[44], exp_cw[44]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            report();
        end
    end

    initial begin
        logic [31:0] words [6];
        words[0] = 32'h0000_0000;
        words[1] = 32'hFFFF_FFFF;
        words[2] = 32'hA5A5_5A5A;
        words[3] = $urandom;
        words[4] = $urandom;
        words[5] = $urandom;

        // R8: reset with nonzero inputs leaves outputs at zero
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (dec_data_o !== '0 || dec_corrected_o !== 1'b0 ||
            dec_nerr_o !== 2'd0 || dec_uncorr_o !== 1'b0) begin
            fails++;
            $display("FAIL R8: got data=%h corr=%b nerr=%0d unc=%b exp all zero",
                     dec_data_o, dec_corrected_o, dec_nerr_o, dec_uncorr_o);
        end
        rst = 1'b0;

        for (int w = 0; w < 6; w++) begin
            logic [31:0] d;
            logic [44:0] cw;
            d  = words[w];
            check_encoder(d);
            cw = ref_cw(d);
            send(cw, d, d, 1'b0, 2'd0, 1'b0, "R4 clean");
            for (int i = 0; i < 45; i++)
                send(cw ^ (45'd1 << i), d, d, 1'b1, 2'd1, 1'b0, "R5 single");
            for (int i = 0; i < 45; i++)
                for (int j = i + 1; j < 45; j++)
                    send(cw ^ (45'd1 << i) ^ (45'd1 << j), d, d, 1'b1, 2'd2, 1'b0,
                         "R6 R9 double");
        end

        for (int t = 0; t < 1500; t++) begin
            logic [31:0] d;
            logic [44:0] cw;
            int a, b, c;
            d = $urandom;
            a = $urandom_range(44);
            do b = $urandom_range(44); while (b == a);
            do c = $urandom_range(44); while (c == a || c == b);
            cw = ref_cw(d) ^ (45'd1 << a) ^ (45'd1 << b) ^ (45'd1 << c);
            send(cw, d, cw[31:0], 1'b0, 2'd0, 1'b1, "R7 R9 triple");
        end

        @(negedge clk);
        compare_head();
        done = 1'b1;
        report();
    end
endmodule